// File: doc/BRIEF.md
# Oversampled NRZI Bit-Clock Recovery Loop

This block takes the hard-limited output of a tone demodulator and samples it several times per symbol. From where level changes fall between samples, it recovers the bit timing. Samples are spaced by a count of base ticks, and one base tick occurs every `TICK_DIV` clock cycles. On one sample per symbol, the decision sample, the block looks at a short record of recent level changes. It then picks a shortened, nominal or lengthened interval for the next sample. This pulls the sampling grid toward the symbol centres without a loop filter.

The decision sample is also NRZI-decoded. An unchanged level since the previous decision reads as 1, and a changed level reads as 0. Decoded bits are packed least significant bit first into 16-bit words, and each finished word is signalled with a one-cycle strobe. The `mode_2x` input selects the sampling mode and is expected to be held steady while the block runs:
- In three-sample mode, the phase machine runs DECIDE → MID_A → MID_B → DECIDE.
- In two-sample mode, it runs DECIDE → MID_A → DECIDE.

The machine advances only on a sample. A signed counter, kept for observation, tallies the corrections: up for late, down for early.

Top module: `nrzi_dpll_rx`

## Requirements
- R1: Reset clears outputs, history, reference sample and correction count, puts the phase machine in DECIDE, and selects the nominal interval. With one clock per tick, the first sample falls on the 4th rising edge after reset release in three-sample mode and on the 6th in two-sample mode, and it is a decision sample.
- R2: On every sample, a change-history register shifts left by one. It takes in 1 when the line differs from the previous sample and 0 otherwise, so that bit 0 holds the newest sample.
- R3: With `mode_2x`=0, the phases cycle DECIDE, MID_A, MID_B. Every interval that follows an intermediate sample is the nominal 4 ticks.
- R4: With `mode_2x`=0, at a decision the history bits [2:0] set the next interval. A value of 001 (late) gives 5 ticks, 100 (early) gives 3 ticks, and any other value gives 4 ticks.
- R5: With `mode_2x`=1, the phases alternate between DECIDE and MID_A. The nominal interval is 6 ticks.
- R6: With `mode_2x`=1, at a decision the history bits [1:0] set the next interval. A value of 01 (late) gives 7 ticks, 10 (early) gives 5 ticks, and any other value gives 6 ticks.
- R7: The decoded bit at a decision is 1 when the line equals the level stored at the previous decision and 0 otherwise. The current level then becomes the stored reference.
- R8: Decoded bits enter bit 16 of a 17-bit register that shifts right and starts at 0x10000. When bit 0 becomes 1, bits [16:1] are issued as the word, so the first decoded bit lands in word bit 0, and the register reloads to 0x10000.
- R9: `word_valid` is high for exactly one cycle per word. `word_out` changes only together with that pulse and holds its value until the next one.
- R10: `corr_count` rises by one on each late correction, falls by one on each early correction, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Hard-limited demodulator level |
| mode_2x | input | 1 | 0: three samples per bit, 1: two samples per bit |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_out | output | WORD_W | Last finished word, first bit in bit 0 |
| corr_count | output | CORR_W | Signed running tally of timing corrections |

## Verification
The bench uses both modes and two kinds of input:
- **Level changes centred between decisions.** In three-sample mode, a two-word mixed pattern with every change placed in the nominal window shows that NRZI decoding, word packing and register reload work without any correction. In two-sample mode, a steady line does the same job, because there any change forces a correction.
- **A single level change placed to look late or early.** In each mode, one change falls where the history window reads late, and another where it reads early. The edge on which the word strobe appears then differs by one tick in each direction, which separates the stretched, shortened and nominal intervals. The sign of the correction count confirms the direction.

// File: rtl/nrzi_dpll_pkg.sv
package nrzi_dpll_pkg;

    // Phase of the current sample within one symbol
    typedef enum logic [1:0] {
        PH_DECIDE = 2'd0,
        PH_MID_A  = 2'd1,
        PH_MID_B  = 2'd2
    } phase_e;

    // Length chosen for the next sample interval
    typedef enum logic [1:0] {
        IV_SHORT = 2'd0,
        IV_NOM   = 2'd1,
        IV_LONG  = 2'd2
    } ivl_e;

endpackage

// File: rtl/nrzi_tick_gen.sv
module nrzi_tick_gen #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV + 1);
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick_o = (div_q >= LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + DW'(1);
    end
endmodule

// File: rtl/nrzi_sample_timer.sv
module nrzi_sample_timer
    import nrzi_dpll_pkg::*;
#(
    parameter int NOM_3X = 4,
    parameter int NOM_2X = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_2x,
    input  ivl_e sel,
    output logic sample_now
);
    localparam int MAX_NOM = (NOM_2X > NOM_3X) ? NOM_2X : NOM_3X;
    localparam int CW      = $clog2(MAX_NOM + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;
    int            nom;

    always_comb begin
        nom = mode_2x ? NOM_2X : NOM_3X;
        unique case (sel)
            IV_SHORT: len = CW'(nom - 1);
            IV_LONG:  len = CW'(nom + 1);
            default:  len = CW'(nom);
        endcase
        sample_now = tick && (cnt_q >= len - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (sample_now) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + CW'(1);
    end

    // Counter never runs past the current interval while settings hold
    p_cnt_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_2x) && $stable(sel)) |-> (cnt_q < len));
endmodule

// File: rtl/nrzi_phase_ctrl.sv
module nrzi_phase_ctrl
    import nrzi_dpll_pkg::*;
#(
    parameter int CORR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_now,
    input  logic                     mode_2x,
    input  logic                     line_in,
    output ivl_e                     sel_q,
    output logic                     decide_now,
    output logic signed [CORR_W-1:0] corr_q
);
    localparam int HIST_W = 3;

    phase_e            state_q, state_d;
    logic              last_q;
    logic [HIST_W-1:0] hist_q, hist_d;
    logic              late, early;
    ivl_e              sel_d;

    // Phase machine: next state
    always_comb begin
        state_d = state_q;
        if (sample_now) begin
            unique case (state_q)
                PH_DECIDE: state_d = PH_MID_A;
                PH_MID_A:  state_d = mode_2x ? PH_DECIDE : PH_MID_B;
                PH_MID_B:  state_d = PH_DECIDE;
                default:   state_d = PH_DECIDE;
            endcase
        end
    end

    // Phase machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_DECIDE;
        else        state_q <= state_d;
    end

    // Outputs of the decision step
    always_comb begin
        hist_d     = {hist_q[HIST_W-2:0], line_in ^ last_q};
        decide_now = sample_now && (state_q == PH_DECIDE);
        if (mode_2x) begin
            late  = (hist_d[1:0] == 2'b01);
            early = (hist_d[1:0] == 2'b10);
        end else begin
            late  = (hist_d == 3'b001);
            early = (hist_d == 3'b100);
        end
        if (!decide_now) sel_d = IV_NOM;
        else if (late)   sel_d = IV_LONG;
        else if (early)  sel_d = IV_SHORT;
        else             sel_d = IV_NOM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            last_q <= 1'b0;
            sel_q  <= IV_NOM;
            corr_q <= '0;
        end else if (sample_now) begin
            hist_q <= hist_d;
            last_q <= line_in;
            sel_q  <= sel_d;
            if (decide_now && late)       corr_q <= corr_q + CORR_W'(1);
            else if (decide_now && early) corr_q <= corr_q - CORR_W'(1);
        end
    end

    p_mid_nominal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && state_q != PH_DECIDE) |=> (sel_q == IV_NOM));

    p_three_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_2x && sample_now && state_q == PH_MID_A) |=> (state_q == PH_MID_B));

    p_two_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_2x && sample_now && state_q == PH_MID_A) |=> (state_q == PH_DECIDE));

    p_corr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_q == $past(corr_q)) || (corr_q == $past(corr_q) + CORR_W'(1)) ||
        (corr_q == $past(corr_q) - CORR_W'(1)));
endmodule

// File: rtl/nrzi_packer.sv
module nrzi_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide_now,
    input  logic              line_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_out
);
    localparam int SW = WORD_W + 1;
    localparam logic [SW-1:0] EMPTY = SW'(1) << WORD_W;

    logic [SW-1:0] sh_q, sh_d;
    logic          ref_q;

    // New bit enters at the top; the marker reaching bit 0 ends a word
    assign sh_d = {line_in == ref_q, sh_q[SW-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= EMPTY;
            ref_q      <= 1'b0;
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            word_valid <= 1'b0;
            if (decide_now) begin
                ref_q <= line_in;
                if (sh_d[0]) begin
                    word_out   <= sh_d[SW-1:1];
                    word_valid <= 1'b1;
                    sh_q       <= EMPTY;
                end else begin
                    sh_q <= sh_d;
                end
            end
        end
    end

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));
endmodule

// File: rtl/nrzi_dpll_rx.sv
module nrzi_dpll_rx
    import nrzi_dpll_pkg::*;
#(
    parameter int TICK_DIV = 1,
    parameter int NOM_3X   = 4,
    parameter int NOM_2X   = 6,
    parameter int WORD_W   = 16,
    parameter int CORR_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_in,
    input  logic                     mode_2x,
    output logic                     word_valid,
    output logic [WORD_W-1:0]        word_out,
    output logic signed [CORR_W-1:0] corr_count
);
    logic tick;
    logic sample_now;
    logic decide_now;
    ivl_e sel;

    nrzi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    nrzi_sample_timer #(.NOM_3X(NOM_3X), .NOM_2X(NOM_2X)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode_2x    (mode_2x),
        .sel        (sel),
        .sample_now (sample_now)
    );

    nrzi_phase_ctrl #(.CORR_W(CORR_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .mode_2x    (mode_2x),
        .line_in    (line_in),
        .sel_q      (sel),
        .decide_now (decide_now),
        .corr_q     (corr_count)
    );

    nrzi_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .decide_now (decide_now),
        .line_in    (line_in),
        .word_valid (word_valid),
        .word_out   (word_out)
    );
endmodule

// File: tb/nrzi_dpll_rx_test.sv
module nrzi_dpll_rx_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_in = 1'b0;
    logic              mode_2x = 1'b0;
    logic              word_valid;
    logic [15:0]       word_out;
    logic signed [7:0] corr_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Results of the last stream
    int          pcnt, hold_err, dbl_err;
    int          pe [2];
    logic [15:0] pw [2];

    nrzi_dpll_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .mode_2x    (mode_2x),
        .word_valid (word_valid),
        .word_out   (word_out),
        .corr_count (corr_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset(input bit m2x);
        @(negedge clk);
        rst_n   = 1'b0;
        mode_2x = m2x;
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive an NRZI stream: the level for bit k (k>=1) is applied after edge 12k+chg_at
    task automatic drive_stream(input bit m2x, input logic [31:0] data, input int nbits,
                                input int chg_at, input int maxn);
        logic        lvl;
        logic [15:0] held;
        bit          prev_v;
        lvl = 1'b0; held = '0; prev_v = 1'b0;
        pcnt = 0; hold_err = 0; dbl_err = 0;
        pe[0] = 0; pe[1] = 0; pw[0] = '0; pw[1] = '0;
        do_reset(m2x);
        for (int n = 1; n <= maxn; n++) begin
            @(negedge clk);
            if (word_valid) begin
                if (prev_v) dbl_err++;
                if (pcnt < 2) begin
                    pe[pcnt] = n;
                    pw[pcnt] = word_out;
                end
                pcnt++;
                held = word_out;
            end else if (word_out !== held) begin
                hold_err++;
            end
            prev_v = word_valid;
            if (n > chg_at && ((n - chg_at) % 12) == 0) begin
                int k;
                k = (n - chg_at) / 12;
                if (k >= 1 && k < nbits && !data[k]) lvl = ~lvl;
                line_in = lvl;
            end
        end
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(word_valid == 1'b0, "R1 reset valid", int'(word_valid), 0);
        chk(word_out == 16'h0, "R1 reset word", int'(word_out), 0);
        chk(corr_count == 8'sd0, "R1 reset corr", int'(corr_count), 0);
    endtask

    // Three-sample mode, changes in nominal window, two words back to back
    task automatic t_nominal_3x();
        drive_stream(1'b0, 32'h3C5A_A5C3, 32, -2, 400);
        chk(pcnt == 2, "R8 word count 3x", pcnt, 2);
        chk(pe[0] == 184, "R1/R3 first word edge 3x", pe[0], 184);
        chk(pw[0] == 16'hA5C3, "R7/R8 first word 3x", int'(pw[0]), 'hA5C3);
        chk(pe[1] == 376, "R8 second word edge 3x", pe[1], 376);
        chk(pw[1] == 16'h3C5A, "R8 reload second word 3x", int'(pw[1]), 'h3C5A);
        chk(corr_count == 8'sd0, "R4 no correction 3x", int'(corr_count), 0);
        chk(hold_err == 0, "R9 word hold", hold_err, 0);
        chk(dbl_err == 0, "R9 single-cycle pulse", dbl_err, 0);
    endtask

    task automatic t_nominal_2x();
        drive_stream(1'b1, 32'h0000_FFFF, 16, -4, 200);
        chk(pcnt == 1, "R5 word count 2x", pcnt, 1);
        chk(pe[0] == 186, "R1/R5 word edge 2x", pe[0], 186);
        chk(pw[0] == 16'hFFFF, "R7 steady line 2x", int'(pw[0]), 'hFFFF);
        chk(corr_count == 8'sd0, "R6 no correction 2x", int'(corr_count), 0);
    endtask

    task automatic t_late_3x();
        drive_stream(1'b0, 32'h0000_FFFD, 16, 1, 200);
        chk(pcnt == 1, "R4 word count late 3x", pcnt, 1);
        chk(pe[0] == 185, "R2/R4 stretched interval 3x", pe[0], 185);
        chk(pw[0] == 16'hFFFD, "R7 word late 3x", int'(pw[0]), 'hFFFD);
        chk(corr_count == 8'sd1, "R10 late count 3x", int'(corr_count), 1);
    endtask

    task automatic t_early_3x();
        drive_stream(1'b0, 32'h0000_FFFD, 16, -7, 200);
        chk(pcnt == 1, "R4 word count early 3x", pcnt, 1);
        chk(pe[0] == 183, "R2/R4 shortened interval 3x", pe[0], 183);
        chk(pw[0] == 16'hFFFD, "R7 word early 3x", int'(pw[0]), 'hFFFD);
        chk(corr_count == -8'sd1, "R10 early count 3x", int'(corr_count), -1);
    endtask

    task automatic t_late_2x();
        drive_stream(1'b1, 32'h0000_FFFD, 16, 3, 200);
        chk(pcnt == 1, "R6 word count late 2x", pcnt, 1);
        chk(pe[0] == 187, "R6 stretched interval 2x", pe[0], 187);
        chk(pw[0] == 16'hFFFD, "R7 word late 2x", int'(pw[0]), 'hFFFD);
        chk(corr_count == 8'sd1, "R10 late count 2x", int'(corr_count), 1);
    endtask

    task automatic t_early_2x();
        drive_stream(1'b1, 32'h0000_FFFD, 16, -4, 200);
        chk(pcnt == 1, "R6 word count early 2x", pcnt, 1);
        chk(pe[0] == 185, "R6 shortened interval 2x", pe[0], 185);
        chk(pw[0] == 16'hFFFD, "R7 word early 2x", int'(pw[0]), 'hFFFD);
        chk(corr_count == -8'sd1, "R10 early count 2x", int'(corr_count), -1);
    endtask

    initial begin
        t_reset();
        t_nominal_3x();
        t_nominal_2x();
        t_late_3x();
        t_early_3x();
        t_late_2x();
        t_early_2x();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule